// File: doc/BRIEF.md
# Dual Page-Buffer Serial Slave

This block is the serial front end of a storage device that holds two independent 264-byte SRAM page buffers. A host selects the block with an active-low chip select and clocks an opcode, an address and data over a four-wire serial link. Write frames load bytes into one buffer starting at a chosen byte. Read frames stream bytes back from a chosen byte. In both cases the byte pointer runs on past the last byte and back to byte 0 for as long as the host keeps clocking.

All pins are sampled by the block's own system clock through a short synchronizer, and serial clock edges are found from the sampled levels. The serial clock must therefore run well below the system clock rate. The idle level of the serial clock is captured at every chip-select assertion. A low level selects mode 0 and a high level selects mode 3. The serial output is given as a data bit plus an output enable, so the pad ring can build the tri-state driver.

Top module: `dpb_serial_slave`

## Requirements
- R1: A frame that opens with opcode 0x84 writes buffer A, and a frame that opens with 0x87 writes buffer B. The opcode is followed by 15 ignored bits and then a 9-bit start address. Data bytes follow at once. Every field is sent MSB first and sampled on the rising serial clock edge.
- R2: Opcodes 0x54 and 0xD4 read buffer A, and opcodes 0x56 and 0xD6 read buffer B. The frame layout is opcode, 15 ignored bits, 9 address bits and 8 ignored bits. Data bytes are then shifted out MSB first. Each bit changes after a falling serial clock edge and is valid at the next rising edge.
- R3: After byte 263 the pointer continues at byte 0. This holds for both reads and writes, and a write keeps accepting bytes until chip select is deasserted.
- R4: A start address of 264 or above selects byte (address − 264).
- R5: A byte is stored only once all 8 of its bits have arrived. An incomplete byte left when chip select rises is dropped, and the buffer byte keeps its old value.
- R6: The two buffers have separate storage. A write to one never alters the other.
- R7: An opcode outside the six listed in R1 and R2 changes no buffer byte. The output enable stays low for the rest of that frame.
- R8: The output enable is high only while chip select is asserted and read data is being shifted out. It is low after reset, during the header of a read, and after chip select rises.
- R9: The clock-mode output takes the serial clock level sampled when chip select falls: 0 for mode 0, 1 for mode 3. It reads 1 after reset and holds its value between chip-select assertions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to sample all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from host to block |
| miso | output | 1 | Serial data from block to host |
| miso_oe | output | 1 | Output enable for the serial data driver |
| clk_mode | output | 1 | Detected clock mode: 0 = mode 0, 1 = mode 3 |

## Verification
Two situations are hard to reach from the pins. The first is the pointer crossing from byte 263 back to byte 0 in both directions. The bench covers it with a write that starts near the top of buffer A and with one long write of 266 bytes into buffer B. It then reads across the seam, and also reads with an out-of-range start address that must alias into the low bytes. The second is a frame that ends in the middle of a byte. The bench clocks a full byte plus three stray bits before raising chip select, then reads both bytes back to confirm that only the complete byte landed.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPCODE,
        PH_PAD,
        PH_ADDR,
        PH_WR_DATA,
        PH_RD_DUMMY,
        PH_RD_DATA,
        PH_SKIP
    } phase_e;

    localparam logic [7:0] OPC_WR_A     = 8'h84;
    localparam logic [7:0] OPC_WR_B     = 8'h87;
    localparam logic [7:0] OPC_RD_A     = 8'h54;
    localparam logic [7:0] OPC_RD_A_ALT = 8'hD4;
    localparam logic [7:0] OPC_RD_B     = 8'h56;
    localparam logic [7:0] OPC_RD_B_ALT = 8'hD6;

    typedef struct packed {
        logic valid;
        logic is_read;
        logic sel;
    } op_info_t;

endpackage

// File: rtl/dpb_pin_sync.sv
module dpb_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic cs_act,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_lvl,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_lvl
);

    logic [STAGES-1:0] cs_pipe_q, sck_pipe_q, mosi_pipe_q;
    logic cs_prev_q, sck_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_pipe_q   <= '1;
            sck_pipe_q  <= '1;
            mosi_pipe_q <= '0;
            cs_prev_q   <= 1'b1;
            sck_prev_q  <= 1'b1;
        end else begin
            cs_pipe_q[0]   <= cs_n;
            sck_pipe_q[0]  <= sck;
            mosi_pipe_q[0] <= mosi;
            for (int i = 1; i < STAGES; i++) begin
                cs_pipe_q[i]   <= cs_pipe_q[i-1];
                sck_pipe_q[i]  <= sck_pipe_q[i-1];
                mosi_pipe_q[i] <= mosi_pipe_q[i-1];
            end
            cs_prev_q  <= cs_pipe_q[STAGES-1];
            sck_prev_q <= sck_pipe_q[STAGES-1];
        end
    end

    always_comb begin
        cs_act   = ~cs_pipe_q[STAGES-1];
        cs_fall  = cs_act & cs_prev_q;
        cs_rise  = ~cs_act & ~cs_prev_q;
        sck_lvl  = sck_pipe_q[STAGES-1];
        sck_rise = sck_lvl & ~sck_prev_q;
        sck_fall = ~sck_lvl & sck_prev_q;
        mosi_lvl = mosi_pipe_q[STAGES-1];
    end

endmodule

// File: rtl/dpb_buf_mem.sv
module dpb_buf_mem #(
    parameter int DEPTH = 264,
    parameter int AW    = $clog2(DEPTH),
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = (int'(raddr) < DEPTH) ? mem_q[raddr] : '0;
    end

    // R3: a write never lands outside the buffer.
    p_waddr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < DEPTH));

endmodule

// File: rtl/dpb_frame_ctrl.sv
module dpb_frame_ctrl
    import dpb_pkg::*;
#(
    parameter int DEPTH      = 264,
    parameter int AW         = $clog2(DEPTH),
    parameter int PAD_BITS   = 15,
    parameter int DUMMY_BITS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          sck_lvl,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          mosi_lvl,
    input  logic [7:0]    rd_byte,
    output logic          wr_en,
    output logic          wr_sel,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] ptr,
    output logic          rd_sel,
    output logic          miso,
    output logic          miso_oe,
    output logic          clk_mode
);

    localparam int L1      = (PAD_BITS > AW) ? PAD_BITS : AW;
    localparam int L2      = (DUMMY_BITS > 8) ? DUMMY_BITS : 8;
    localparam int LONGEST = (L1 > L2) ? L1 : L2;
    localparam int CW      = $clog2(LONGEST + 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic [7:0]    shift;
        logic [AW-1:0] ptr;
        logic          sel;
        logic          is_read;
        logic          mode;
        logic [7:0]    out_byte;
        logic [2:0]    out_bit;
        logic          miso;
        logic          oe;
    } ctrl_t;

    ctrl_t q, d;

    function automatic op_info_t decode_op(input logic [7:0] op);
        op_info_t r;
        r = '0;
        case (op)
            OPC_WR_A:               r = '{valid: 1'b1, is_read: 1'b0, sel: 1'b0};
            OPC_WR_B:               r = '{valid: 1'b1, is_read: 1'b0, sel: 1'b1};
            OPC_RD_A, OPC_RD_A_ALT: r = '{valid: 1'b1, is_read: 1'b1, sel: 1'b0};
            OPC_RD_B, OPC_RD_B_ALT: r = '{valid: 1'b1, is_read: 1'b1, sel: 1'b1};
            default:                r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    logic [7:0]    byte_in;
    logic [AW-1:0] addr_in;
    op_info_t      op_info;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        byte_in = {q.shift[6:0], mosi_lvl};
        addr_in = {q.ptr[AW-2:0], mosi_lvl};
        op_info = decode_op(byte_in);

        if (cs_rise) begin
            d.phase = PH_IDLE;
            d.oe    = 1'b0;
        end else if (cs_fall) begin
            d.phase = PH_OPCODE;
            d.cnt   = '0;
            d.mode  = sck_lvl;
            d.oe    = 1'b0;
        end else if (cs_act && sck_rise) begin
            case (q.phase)
                PH_OPCODE: begin
                    d.shift = byte_in;
                    if (q.cnt == CW'(7)) begin
                        d.cnt     = '0;
                        d.sel     = op_info.sel;
                        d.is_read = op_info.is_read;
                        d.phase   = op_info.valid ? PH_PAD : PH_SKIP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                PH_PAD: begin
                    if (q.cnt == CW'(PAD_BITS - 1)) begin
                        d.cnt   = '0;
                        d.phase = PH_ADDR;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                PH_ADDR: begin
                    d.ptr = addr_in;
                    if (q.cnt == CW'(AW - 1)) begin
                        d.cnt   = '0;
                        d.ptr   = (int'(addr_in) >= DEPTH) ? addr_in - AW'(DEPTH) : addr_in;
                        d.phase = q.is_read ? PH_RD_DUMMY : PH_WR_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                PH_WR_DATA: begin
                    d.shift = byte_in;
                    if (q.cnt == CW'(7)) begin
                        wr_en = 1'b1;
                        d.cnt = '0;
                        d.ptr = step_ptr(q.ptr);
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                PH_RD_DUMMY: begin
                    if (q.cnt == CW'(DUMMY_BITS - 1)) begin
                        d.cnt      = '0;
                        d.phase    = PH_RD_DATA;
                        d.out_byte = rd_byte;
                        d.out_bit  = '0;
                        d.ptr      = step_ptr(q.ptr);
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (cs_act && sck_fall && q.phase == PH_RD_DATA) begin
            d.miso = q.out_byte[7];
            d.oe   = 1'b1;
            if (q.out_bit == 3'd7) begin
                d.out_byte = rd_byte;
                d.out_bit  = '0;
                d.ptr      = step_ptr(q.ptr);
            end else begin
                d.out_byte = {q.out_byte[6:0], 1'b0};
                d.out_bit  = q.out_bit + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
            q.mode  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        wr_sel   = q.sel;
        wr_data  = byte_in;
        ptr      = q.ptr;
        rd_sel   = q.sel;
        miso     = q.miso;
        miso_oe  = q.oe;
        clk_mode = q.mode;
    end

    // R8: once deselected, the output driver is off from the next cycle.
    p_oe_off_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !miso_oe);

    // R3: the data pointer stays inside the buffer during data phases.
    p_ptr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase inside {PH_WR_DATA, PH_RD_DUMMY, PH_RD_DATA}) |-> (int'(q.ptr) < DEPTH));

    // R3: a committed write at the last byte sends the pointer to byte 0.
    p_ptr_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(q.ptr) == DEPTH - 1) |=> (q.ptr == '0));

    // R9: the detected mode changes only at a chip-select assertion.
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_fall |=> $stable(q.mode));

    // R7: a frame with a rejected opcode never writes and never drives.
    p_skip_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_SKIP) |-> (!wr_en && !q.oe));

endmodule

// File: rtl/dpb_serial_slave.sv
module dpb_serial_slave #(
    parameter int DEPTH       = 264,
    parameter int PAD_BITS    = 15,
    parameter int DUMMY_BITS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic miso_oe,
    output logic clk_mode
);

    localparam int AW    = $clog2(DEPTH);
    localparam int N_BUF = 2;

    logic cs_act, cs_fall, cs_rise, sck_lvl, sck_rise, sck_fall, mosi_lvl;
    logic          wr_en, wr_sel, rd_sel;
    logic [7:0]    wr_data, rd_byte;
    logic [AW-1:0] ptr;
    logic [7:0]    buf_rdata [N_BUF];

    dpb_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .mosi     (mosi),
        .cs_act   (cs_act),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sck_lvl  (sck_lvl),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_lvl (mosi_lvl)
    );

    dpb_frame_ctrl #(
        .DEPTH      (DEPTH),
        .AW         (AW),
        .PAD_BITS   (PAD_BITS),
        .DUMMY_BITS (DUMMY_BITS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sck_lvl  (sck_lvl),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_lvl (mosi_lvl),
        .rd_byte  (rd_byte),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .ptr      (ptr),
        .rd_sel   (rd_sel),
        .miso     (miso),
        .miso_oe  (miso_oe),
        .clk_mode (clk_mode)
    );

    for (genvar g = 0; g < N_BUF; g++) begin : g_buf
        dpb_buf_mem #(.DEPTH(DEPTH), .AW(AW), .DW(8)) u_mem (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && (wr_sel == 1'(g))),
            .waddr (ptr),
            .wdata (wr_data),
            .raddr (ptr),
            .rdata (buf_rdata[g])
        );
    end

    always_comb begin
        rd_byte = buf_rdata[rd_sel];
    end

endmodule

// File: tb/dpb_serial_slave_bench.sv
module dpb_serial_slave_bench;

    localparam int DEPTH = 264;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b1;
    logic mosi = 1'b0;
    logic miso, miso_oe, clk_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit oe_seen;
    bit oe_lost;
    logic [7:0] exp_a [DEPTH];
    logic [7:0] exp_b [DEPTH];

    always #4 clk = ~clk;

    dpb_serial_slave u_dpb_serial_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .mosi     (mosi),
        .miso     (miso),
        .miso_oe  (miso_oe),
        .clk_mode (clk_mode)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic tx_bit(input bit b);
        sck = 1'b0;
        mosi = b;
        wait_clk(HALF);
        if (miso_oe) oe_seen = 1'b1;
        sck = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic tx_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) tx_bit(v[i]);
    endtask

    task automatic rx_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0;
            wait_clk(HALF);
            v[i] = miso;
            if (miso_oe !== 1'b1) oe_lost = 1'b1;
            sck = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic begin_frame(input bit m3);
        sck = m3;
        wait_clk(HALF);
        cs_n = 1'b0;
        oe_seen = 1'b0;
        wait_clk(HALF);
        check(clk_mode === m3, "R9", "mode at select", int'(clk_mode), int'(m3));
    endtask

    task automatic end_frame(input bit m3);
        if (!m3) begin
            sck = 1'b0;
            wait_clk(HALF);
        end
        cs_n = 1'b1;
        wait_clk(HALF);
        check(miso_oe === 1'b0, "R8", "oe after deselect", int'(miso_oe), 0);
    endtask

    task automatic header(input logic [7:0] op, input logic [8:0] addr);
        tx_byte(op);
        for (int i = 0; i < 15; i++) tx_bit(i[0]);
        for (int i = 8; i >= 0; i--) tx_bit(addr[i]);
    endtask

    function automatic int fold(input logic [8:0] addr);
        return (int'(addr) >= DEPTH) ? int'(addr) - DEPTH : int'(addr);
    endfunction

    task automatic buf_write(input bit m3, input bit which, input logic [8:0] addr,
                             input logic [7:0] data [$]);
        int idx;
        idx = fold(addr);
        begin_frame(m3);
        header(which ? 8'h87 : 8'h84, addr);
        foreach (data[k]) begin
            tx_byte(data[k]);
            if (which) exp_b[idx] = data[k];
            else       exp_a[idx] = data[k];
            idx = (idx == DEPTH - 1) ? 0 : idx + 1;
        end
        end_frame(m3);
    endtask

    task automatic buf_read(input bit m3, input logic [7:0] op, input bit which,
                            input logic [8:0] addr, input int n, input string req);
        int idx;
        logic [7:0] got;
        logic [7:0] want;
        idx = fold(addr);
        begin_frame(m3);
        header(op, addr);
        for (int i = 0; i < 8; i++) tx_bit(1'b1);
        check(!oe_seen, "R8", "oe during read header", int'(oe_seen), 0);
        oe_lost = 1'b0;
        for (int i = 0; i < n; i++) begin
            rx_byte(got);
            want = which ? exp_b[idx] : exp_a[idx];
            check(got === want, req, $sformatf("byte at %0d", idx), int'(got), int'(want));
            idx = (idx == DEPTH - 1) ? 0 : idx + 1;
        end
        check(!oe_lost, "R8", "oe during read data", int'(oe_lost), 0);
        end_frame(m3);
    endtask

    task automatic t_reset;
        check(miso_oe === 1'b0, "R8", "oe after reset", int'(miso_oe), 0);
        check(clk_mode === 1'b1, "R9", "mode after reset", int'(clk_mode), 1);
    endtask

    task automatic t_write_read_a;
        logic [7:0] q [$];
        q = '{8'h11, 8'h22, 8'h33, 8'hA5};
        buf_write(1'b1, 1'b0, 9'd5, q);
        buf_read(1'b1, 8'h54, 1'b0, 9'd5, 4, "R1 R2");
    endtask

    task automatic t_separate_mode0;
        logic [7:0] q [$];
        q = '{8'h5A, 8'hC3};
        buf_write(1'b0, 1'b1, 9'd5, q);
        buf_read(1'b0, 8'hD4, 1'b0, 9'd5, 2, "R6");
        buf_read(1'b0, 8'hD6, 1'b1, 9'd5, 2, "R2");
        buf_read(1'b1, 8'h56, 1'b1, 9'd5, 2, "R2");
    endtask

    task automatic t_wrap;
        logic [7:0] q [$];
        q = '{8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE4, 8'hE5};
        buf_write(1'b1, 1'b0, 9'd260, q);
        buf_read(1'b0, 8'h54, 1'b0, 9'd262, 4, "R3");
        q = {};
        for (int i = 0; i < DEPTH + 2; i++) q.push_back(8'((i * 7 + 3) & 8'hFF));
        buf_write(1'b0, 1'b1, 9'd0, q);
        buf_read(1'b1, 8'h56, 1'b1, 9'd263, 3, "R3");
        buf_read(1'b0, 8'hD4, 1'b0, 9'd5, 1, "R6");
    endtask

    task automatic t_alias;
        buf_read(1'b1, 8'h54, 1'b0, 9'd265, 2, "R4");
        buf_read(1'b0, 8'h56, 1'b1, 9'd511, 2, "R4");
    endtask

    task automatic t_partial;
        logic [7:0] q [$];
        q = '{8'h01, 8'h02};
        buf_write(1'b1, 1'b0, 9'd20, q);
        begin_frame(1'b1);
        header(8'h84, 9'd20);
        tx_byte(8'h3C);
        tx_bit(1'b1);
        tx_bit(1'b0);
        tx_bit(1'b1);
        end_frame(1'b1);
        exp_a[20] = 8'h3C;
        buf_read(1'b1, 8'h54, 1'b0, 9'd20, 2, "R5");
    endtask

    task automatic t_unknown;
        begin_frame(1'b1);
        header(8'h83, 9'd5);
        tx_byte(8'h77);
        tx_byte(8'h77);
        for (int i = 0; i < 16; i++) tx_bit(1'b0);
        check(!oe_seen, "R7", "oe after bad opcode", int'(oe_seen), 0);
        end_frame(1'b1);
        begin_frame(1'b0);
        header(8'h55, 9'd6);
        tx_byte(8'h99);
        check(!oe_seen, "R7", "oe after bad opcode", int'(oe_seen), 0);
        end_frame(1'b0);
        buf_read(1'b1, 8'h54, 1'b0, 9'd5, 2, "R7");
        buf_read(1'b1, 8'h56, 1'b1, 9'd5, 2, "R7");
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_write_read_a();
        t_separate_mode0();
        t_wrap();
        t_alias();
        t_partial();
        t_unknown();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule